// File: doc/BRIEF.md
# Low-Load Burst Sequencer

This block is the digital sequencer of a current-mode switching regulator under very light load. It takes single-bit comparator flags on the regulation voltage and on the current-sense signal, together with the value of a 3-bit load-level up/down counter. From these it decides when the converter drops into a low-power burst mode, when switching bursts run inside that mode, and when the mode ends.

Entry is qualified. The regulation signal must sit below the entry level while the load counter is saturated, and both conditions must persist through a blanking interval before the burst flag sets. Inside burst mode, bias and switching follow a hysteresis band between two comparator levels. While switching, an internal fixed-rate timer starts each gate pulse. Each pulse ends on a current-sense trip or at half the period, whichever comes first. When the regulation signal climbs past the exit level, the block leaves burst mode and issues a one-cycle request that presets the load counter to 1.

All time bases run off a clock-enable tick. The blanking length and the switching period are computed from parameters: the tick rate, the switching rate and the blanking time. `burst_on` also serves as the select for the reduced current limit; it reads low once full current is restored.

Top module: `burst_seq_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `burst_on`, `bias_en`, `gate_en` and `cnt_preset` at that edge. All four read 0 in the first cycle after release.
- R2: Every comparator input passes through two flip-flop stages. A flag driven between edges N and N+1 first changes a registered output at edge N+3.
- R3: `burst_on` sets only after `cmp_entry_lo`=1 and `load_cnt` at its maximum value (all ones, 7 for 3 bits) have held together for BLANK_TICKS ticks. A counter value below the maximum never leads to entry.
- R4: If either entry condition drops during blanking, the blanking count clears. A full BLANK_TICKS interval is then needed after both conditions hold again.
- R5: After entry, `bias_en` and `gate_en` stay 0 until `cmp_burst_hi`=1, which sets `bias_en`. `bias_en` is never 1 while `burst_on` is 0.
- R6: Once set, `bias_en` stays 1 until `cmp_burst_lo`=1. Once cleared, it stays 0 until `cmp_burst_hi`=1 again.
- R7: While `bias_en` is 1, gate pulses start every PERIOD_TICKS ticks. The first pulse rises on the tick after `bias_en` rises.
- R8: A gate pulse ends after PERIOD_TICKS/2 ticks or at a synchronized `cmp_cs_trip`, whichever comes first. `gate_en` is 0 whenever `bias_en` is 0.
- R9: A synchronized `cmp_exit_hi`=1 clears `burst_on`, `bias_en` and `gate_en` at the same edge.
- R10: `cnt_preset` is a single-cycle pulse in the first cycle after `burst_on` falls because of an exit. `cnt_load_val` is constant 1.
- R11: When the exit and entry conditions are true together, the exit wins and `burst_on` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock enable for blanking and switching timers |
| cmp_entry_lo | input | 1 | 1 when regulation voltage is below the entry level |
| cmp_burst_hi | input | 1 | 1 when regulation voltage is above the burst-high level |
| cmp_burst_lo | input | 1 | 1 when regulation voltage is below the burst-low level |
| cmp_exit_hi | input | 1 | 1 when regulation voltage is above the exit level |
| cmp_cs_trip | input | 1 | 1 when the current-sense comparator has tripped |
| load_cnt | input | CNT_W | Load-level up/down counter value |
| gate_en | output | 1 | Gate drive enable for the power switch |
| burst_on | output | 1 | Burst mode active; also selects the reduced current limit |
| bias_en | output | 1 | Internal bias enable during a burst |
| cnt_preset | output | 1 | One-cycle request to load the up/down counter |
| cnt_load_val | output | CNT_W | Value to load into the counter (1) |

## Verification
The bench builds the block with TICK_HZ=640000, SW_HZ=80000 and BLANK_US=100, and holds the tick high on every clock. These values give an 8-cycle switching period, a 4-cycle duty cap and a 64-cycle blanking interval. The blanking restart, the current-sense cut against the duty cap and the exit-over-entry priority can therefore each be checked to the exact cycle within a few hundred clocks. Every expected edge is placed from the three-register input path and the period arithmetic, not from the design.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   localparam int NUM_CMP = 5;
   localparam int CMP_ENT = 0;
   localparam int CMP_BH  = 1;
   localparam int CMP_BL  = 2;
   localparam int CMP_EX  = 3;
   localparam int CMP_CS  = 4;
   typedef logic [NUM_CMP-1:0] cmp_vec_t;

   function automatic int blank_ticks(input int tick_hz, input int blank_us);
      return ((tick_hz / 1000) * blank_us) / 1000;
   endfunction

   function automatic int period_ticks(input int tick_hz, input int sw_hz);
      return tick_hz / sw_hz;
   endfunction
endpackage

// File: rtl/bsq_sync.sv
module bsq_sync #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic st1, st2;
         always_ff @(posedge clk) begin
            if (rst) begin
               st1 <= 1'b0;
               st2 <= 1'b0;
            end else begin
               st1 <= d[i];
               st2 <= st1;
            end
         end
         assign q[i] = st2;
      end
   endgenerate
endmodule

// File: rtl/bsq_blank.sv
module bsq_blank #(
   parameter int BLANK_TICKS = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic qual,
   output logic hit
);
   localparam int BW = (BLANK_TICKS > 1) ? $clog2(BLANK_TICKS) : 1;
   localparam logic [BW-1:0] LAST = BW'(BLANK_TICKS - 1);

   logic [BW-1:0] cnt;

   assign hit = qual & tick & (cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst || !qual)
         cnt <= '0;
      else if (tick && cnt != LAST)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/bsq_pulse.sv
module bsq_pulse #(
   parameter int PERIOD = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic run,
   input  logic cs_trip,
   output logic gate
);
   localparam int PW   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [PW-1:0] LASTP = PW'(PERIOD - 1);
   localparam logic [PW-1:0] HALFP = PW'(PERIOD / 2);

   logic [PW-1:0] pc;
   logic          g_q;

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         pc  <= '0;
         g_q <= 1'b0;
      end else begin
         if (tick)
            pc <= (pc == LASTP) ? '0 : pc + 1'b1;
         if (cs_trip)
            g_q <= 1'b0;
         else if (tick && pc == '0)
            g_q <= 1'b1;
         else if (tick && pc == HALFP)
            g_q <= 1'b0;
      end
   end

   assign gate = g_q;
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
   import burst_seq_pkg::*;
#(
   parameter int CNT_W      = 3,
   parameter int PRESET_VAL = 1,
   parameter int TICK_HZ    = 8_000_000,
   parameter int SW_HZ      = 80_000,
   parameter int BLANK_US   = 24_000
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             cmp_entry_lo,
   input  logic             cmp_burst_hi,
   input  logic             cmp_burst_lo,
   input  logic             cmp_exit_hi,
   input  logic             cmp_cs_trip,
   input  logic [CNT_W-1:0] load_cnt,
   output logic             gate_en,
   output logic             burst_on,
   output logic             bias_en,
   output logic             cnt_preset,
   output logic [CNT_W-1:0] cnt_load_val
);
   localparam int BLANK_TICKS  = blank_ticks(TICK_HZ, BLANK_US);
   localparam int PERIOD_TICKS = period_ticks(TICK_HZ, SW_HZ);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_cntw
         $error("CNT_W must be at least 2");
      end
      if (PERIOD_TICKS < 2 || (PERIOD_TICKS % 2) != 0) begin : g_bad_period
         $error("switching period must be an even tick count of at least 2");
      end
      if (BLANK_TICKS < 1) begin : g_bad_blank
         $error("blanking interval must cover at least one tick");
      end
      if (PRESET_VAL < 0 || PRESET_VAL > (1 << CNT_W) - 1) begin : g_bad_preset
         $error("PRESET_VAL does not fit CNT_W");
      end
   endgenerate

   cmp_vec_t raw_v, syn_v;
   logic ent_s, bh_s, bl_s, ex_s, cs_s;

   assign raw_v[CMP_ENT] = cmp_entry_lo;
   assign raw_v[CMP_BH]  = cmp_burst_hi;
   assign raw_v[CMP_BL]  = cmp_burst_lo;
   assign raw_v[CMP_EX]  = cmp_exit_hi;
   assign raw_v[CMP_CS]  = cmp_cs_trip;

   bsq_sync #(.N(NUM_CMP)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_v),
      .q   (syn_v)
   );

   assign ent_s = syn_v[CMP_ENT];
   assign bh_s  = syn_v[CMP_BH];
   assign bl_s  = syn_v[CMP_BL];
   assign ex_s  = syn_v[CMP_EX];
   assign cs_s  = syn_v[CMP_CS];

   logic burst_q, run_q, preset_q;
   logic qual, hit, gate_raw;

   assign qual = ent_s & (load_cnt == CNT_MAX) & ~burst_q;

   bsq_blank #(.BLANK_TICKS(BLANK_TICKS)) u_blank (
      .clk  (clk),
      .rst  (rst),
      .tick (tick),
      .qual (qual),
      .hit  (hit)
   );

   always_ff @(posedge clk) begin
      if (rst)       burst_q <= 1'b0;
      else if (ex_s) burst_q <= 1'b0;
      else if (hit)  burst_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst || !burst_q || ex_s)
         run_q <= 1'b0;
      else if (run_q)
         run_q <= ~bl_s;
      else
         run_q <= bh_s;
   end

   always_ff @(posedge clk) begin
      if (rst) preset_q <= 1'b0;
      else     preset_q <= burst_q & ex_s;
   end

   bsq_pulse #(.PERIOD(PERIOD_TICKS)) u_pulse (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .run     (run_q),
      .cs_trip (cs_s),
      .gate    (gate_raw)
   );

   assign gate_en      = gate_raw & run_q;
   assign burst_on     = burst_q;
   assign bias_en      = run_q;
   assign cnt_preset   = preset_q;
   assign cnt_load_val = CNT_W'(PRESET_VAL);
endmodule

// File: rtl/bsq_chk.sv
module bsq_chk #(
   parameter int CNT_W   = 3,
   parameter int TICK_HZ = 8_000_000,
   parameter int SW_HZ   = 80_000
) (
   input logic             clk,
   input logic             rst,
   input logic             tick,
   input logic             gate_en,
   input logic             burst_on,
   input logic             bias_en,
   input logic             cnt_preset,
   input logic             ex_s,
   input logic [CNT_W-1:0] load_cnt
);
   localparam int HALF = (TICK_HZ / SW_HZ) / 2;

   logic [31:0] on_ticks;
   always_ff @(posedge clk) begin
      if (rst || !gate_en)  on_ticks <= '0;
      else if (tick)        on_ticks <= on_ticks + 1'b1;
   end

   // R8
   gate_needs_bias_chk: assert property (@(posedge clk) disable iff (rst)
      gate_en |-> bias_en);

   // R8
   duty_cap_chk: assert property (@(posedge clk) disable iff (rst)
      gate_en |-> (on_ticks < 32'(HALF)));

   // R5
   bias_needs_burst_chk: assert property (@(posedge clk) disable iff (rst)
      bias_en |-> burst_on);

   // R10
   preset_single_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_preset |=> !cnt_preset);

   // R10
   preset_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(burst_on) |-> cnt_preset);

   // R9
   exit_clears_chk: assert property (@(posedge clk) disable iff (rst)
      ex_s |=> (!burst_on && !bias_en && !gate_en));

   // R3
   entry_at_max_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(burst_on) |-> ($past(load_cnt) == {CNT_W{1'b1}}));
endmodule

bind burst_seq_ctrl bsq_chk #(
   .CNT_W   (CNT_W),
   .TICK_HZ (TICK_HZ),
   .SW_HZ   (SW_HZ)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .tick       (tick),
   .gate_en    (gate_en),
   .burst_on   (burst_on),
   .bias_en    (bias_en),
   .cnt_preset (cnt_preset),
   .ex_s       (ex_s),
   .load_cnt   (load_cnt)
);

// File: tb/sim_burst_seq_ctrl.sv
module sim_burst_seq_ctrl;
   localparam int CNT_W = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick = 1'b1;
   logic ent = 1'b0, bh = 1'b0, bl = 1'b0, ex = 1'b0, cs = 1'b0;
   logic [CNT_W-1:0] load = '0;
   logic gate_en, burst_on, bias_en, cnt_preset;
   logic [CNT_W-1:0] cnt_load_val;

   always #10 clk = ~clk;

   burst_seq_ctrl #(
      .CNT_W(CNT_W), .PRESET_VAL(1),
      .TICK_HZ(640_000), .SW_HZ(80_000), .BLANK_US(100)
   ) u0 (
      .clk(clk), .rst(rst), .tick(tick),
      .cmp_entry_lo(ent), .cmp_burst_hi(bh), .cmp_burst_lo(bl),
      .cmp_exit_hi(ex), .cmp_cs_trip(cs), .load_cnt(load),
      .gate_en(gate_en), .burst_on(burst_on), .bias_en(bias_en),
      .cnt_preset(cnt_preset), .cnt_load_val(cnt_load_val)
   );

   localparam int S_BURST = 0, S_BIAS = 1, S_GATE = 2, S_PRE = 3;

   typedef struct {
      int unsigned cyc;
      int          sig;
      logic        val;
      string       req;
   } exp_t;

   exp_t sbq[$];
   int unsigned cyc = 0;
   int tests = 0;
   int fails = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic probe(input int s);
      case (s)
         S_BURST: return burst_on;
         S_BIAS:  return bias_en;
         S_GATE:  return gate_en;
         default: return cnt_preset;
      endcase
   endfunction

   function automatic string sname(input int s);
      case (s)
         S_BURST: return "burst_on";
         S_BIAS:  return "bias_en";
         S_GATE:  return "gate_en";
         default: return "cnt_preset";
      endcase
   endfunction

   task automatic expect_at(input int unsigned off, input int sig, input logic val, input string req);
      exp_t e;
      e.cyc = cyc + off;
      e.sig = sig;
      e.val = val;
      e.req = req;
      sbq.push_back(e);
   endtask

   always @(negedge clk) begin
      int i;
      i = 0;
      while (i < sbq.size()) begin
         if (sbq[i].cyc == cyc) begin
            tests++;
            if (probe(sbq[i].sig) !== sbq[i].val) begin
               fails++;
               $display("FAIL %s cyc %0d %s actual %b expected %b", sbq[i].req, cyc,
                        sname(sbq[i].sig), probe(sbq[i].sig), sbq[i].val);
            end
            sbq.delete(i);
         end else begin
            i++;
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      step(5);
      rst = 1'b0;
      // R1 reset state
      expect_at(1, S_BURST, 0, "R1");
      expect_at(1, S_BIAS,  0, "R1");
      expect_at(1, S_GATE,  0, "R1");
      expect_at(1, S_PRE,   0, "R1");
      step(3);

      // R3 counter below maximum never enters
      load = 3'd6; ent = 1'b1;
      step(100);
      expect_at(1, S_BURST, 0, "R3");
      ent = 1'b0; load = 3'd7;
      step(10);

      // R4 blanking restarts after a drop
      ent = 1'b1;
      expect_at(66, S_BURST, 0, "R4");
      step(40);
      ent = 1'b0;
      step(10);
      ent = 1'b1;
      expect_at(65, S_BURST, 0, "R3");
      expect_at(66, S_BURST, 1, "R3");
      expect_at(66, S_BIAS,  0, "R5");
      step(70);
      ent = 1'b0;
      // R5 held off until burst-high
      expect_at(3, S_BIAS, 0, "R5");
      expect_at(3, S_GATE, 0, "R5");
      step(10);

      // R2, R5, R7 start of switching
      bh = 1'b1;
      expect_at(2,  S_BIAS, 0, "R2");
      expect_at(3,  S_BIAS, 1, "R5");
      expect_at(3,  S_GATE, 0, "R7");
      expect_at(4,  S_GATE, 1, "R7");
      expect_at(7,  S_GATE, 1, "R8");
      expect_at(8,  S_GATE, 0, "R8");
      expect_at(11, S_GATE, 0, "R7");
      expect_at(12, S_GATE, 1, "R7");
      step(1);
      bh = 1'b0;
      step(19);

      // R8 current-sense trip cuts the pulse
      cs = 1'b1;
      expect_at(2, S_GATE, 1, "R8");
      expect_at(3, S_GATE, 0, "R8");
      expect_at(8, S_GATE, 1, "R7");
      step(1);
      cs = 1'b0;
      step(20);

      // R6 burst-low stops the burst
      bl = 1'b1;
      expect_at(2, S_BIAS,  1, "R6");
      expect_at(3, S_BIAS,  0, "R6");
      expect_at(3, S_GATE,  0, "R8");
      expect_at(5, S_GATE,  0, "R8");
      expect_at(5, S_BURST, 1, "R6");
      step(1);
      bl = 1'b0;
      step(10);
      expect_at(1, S_BIAS, 0, "R6");
      step(5);
      bh = 1'b1;
      expect_at(3, S_BIAS, 1, "R6");
      step(10);

      // R9, R10 exit and counter preset
      ex = 1'b1; bh = 1'b0;
      expect_at(2, S_BURST, 1, "R9");
      expect_at(3, S_BURST, 0, "R9");
      expect_at(3, S_BIAS,  0, "R9");
      expect_at(3, S_GATE,  0, "R9");
      expect_at(2, S_PRE,   0, "R10");
      expect_at(3, S_PRE,   1, "R10");
      expect_at(4, S_PRE,   0, "R10");
      step(6);
      ex = 1'b0;
      tests++;
      if (cnt_load_val !== 3'd1) begin
         fails++;
         $display("FAIL R10 cnt_load_val actual %0d expected 1", cnt_load_val);
      end
      step(10);

      // R11 exit outranks entry
      ex = 1'b1; ent = 1'b1; load = 3'd7;
      step(100);
      expect_at(1, S_BURST, 0, "R11");
      expect_at(1, S_PRE,   0, "R11");
      step(5);
      ex = 1'b0;
      expect_at(2, S_BURST, 0, "R11");
      expect_at(3, S_BURST, 1, "R11");
      step(5);
      ent = 1'b0;

      // R1 reset during a running burst
      bh = 1'b1;
      step(10);
      rst = 1'b1;
      expect_at(1, S_BURST, 0, "R1");
      expect_at(1, S_BIAS,  0, "R1");
      expect_at(1, S_GATE,  0, "R1");
      step(3);
      rst = 1'b0; bh = 1'b0;
      step(5);

      while (sbq.size() > 0) begin
         fails++;
         $display("FAIL %s %s never sampled actual - expected %b", sbq[0].req,
                  sname(sbq[0].sig), sbq[0].val);
         void'(sbq.pop_front());
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule